// File: doc/BRIEF.md
# Snapshot Counter with Latch and Clear Commands

This block keeps a free-running counter, 64 bits wide by default, that advances on every clock cycle in which a tick-enable input is high. Software never reads the live counter. It reads a snapshot held in a set of bus-width words. A write to a command register with the capture bit set copies the running count into those words in one cycle, so the low and high halves always come from the same instant.

The command register also has a zeroing bit that clears the snapshot words. Both command bits act in the cycle of the write and never stay set in the stored register. Software may also overwrite any snapshot word directly. The counter itself is touched only by reset and by the tick input. The register port is a plain single-cycle write strobe and a read strobe. Read data comes back one cycle later, qualified by a valid flag.

Top module: `snapshot_counter`

## Requirements
- R1: The address map is: word index 0 is the low snapshot word (count bits DATA_W-1:0), word index 1 is the high snapshot word (the next DATA_W bits), and address WORDS (2 by default) is the command register.
- R2: The running counter increases by exactly one at each clock edge where tickEn is high, holds its value when tickEn is low, and wraps modulo 2^CNT_W.
- R3: A command-register write with bit 1 (capture) set copies the counter value present at that edge, before that edge's increment, into the snapshot words.
- R4: Bits 1 and 0 of the command register always read back as 0. Bits DATA_W-1 down to 2 read back the last value written to them.
- R5: A command-register write with bit 0 (zero) set leaves every snapshot word at 0.
- R6: A command-register write with both bits set captures first and then zeroes, so every snapshot word reads 0.
- R7: A write to a snapshot word's address replaces only that word. Other words and the running counter are unaffected.
- R8: After reset, the counter, every snapshot word and the command register are 0, and rdValid is low.
- R9: A read issued with rdEn at one edge shows up on rdData, with rdValid high, after the next edge. The data reflects the register contents from before any write in that same edge.
- R10: A command-register write with both bits 1 and 0 clear leaves the snapshot words unchanged.
- R11: Addresses above the command register read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter advances on cycles where this is high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid one cycle after rdEn |
| rdValid | output | 1 | Marks rdData as carrying a read result |

## Verification
The assertions assume that reset is held low for at least one clock edge. They also assume that a read and a write never target the port in the same cycle, which leaves the ordering rule of R9 visible only through sequential accesses. The stimulus drives every strobe for exactly one cycle, on the falling edge, and never overlaps a read with a write. The counter cannot reach 2^64 in a short run, so wraparound is exercised on a second, narrow instance with 8-bit count and 4-bit words. That instance shares the same bus and tick stimulus.

// File: rtl/snapctr_pkg.sv
package snapctr_pkg;
  // widest word index the strobe struct can carry
  localparam int IDX_W = 4;
  // command bit positions inside the command register
  localparam int CAPTURE_BIT = 1;
  localparam int ZERO_BIT    = 0;

  typedef struct packed {
    logic             capture;
    logic             zero;
    logic             wordWr;
    logic [IDX_W-1:0] wordIdx;
  } strobe_t;
endpackage

// File: rtl/snapctr_ctrl.sv
module snapctr_ctrl
  import snapctr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int WORDS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strobes,
  output logic [DATA_W-1:0] ctrlVal
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(WORDS);

  logic cmdHit;
  assign cmdHit = wrEn && (addr == CMD_ADDR);

  // decode one write into at most one action group
  always_comb begin
    strobes = '0;
    if (cmdHit) begin
      strobes.capture = wrData[CAPTURE_BIT];
      strobes.zero    = wrData[ZERO_BIT];
    end else if (wrEn && (addr < CMD_ADDR)) begin
      strobes.wordWr  = 1'b1;
      strobes.wordIdx = IDX_W'(addr);
    end
  end

  // command bits are consumed in the write cycle and never stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ctrlVal <= '0;
    else if (cmdHit)
      ctrlVal <= {wrData[DATA_W-1:2], 2'b00};
  end

  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.capture | strobes.zero, strobes.wordWr}));

  assert_word_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wordWr |-> (strobes.wordIdx < IDX_W'(WORDS)));
endmodule

// File: rtl/snapctr_datapath.sv
module snapctr_datapath
  import snapctr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int WORDS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] ctrlVal,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] snapWord [WORDS];
  logic [DATA_W-1:0] rdMux;
  logic              rdWasCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cnt <= '0;
    else if (tickEn) cnt <= cnt + 1'b1;
  end

  // zero wins over capture, so a combined command ends at zero
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        snapWord[w] <= '0;
      else if (strobes.zero)
        snapWord[w] <= '0;
      else if (strobes.capture)
        snapWord[w] <= cnt[w*DATA_W +: DATA_W];
      else if (strobes.wordWr && (strobes.wordIdx == IDX_W'(w)))
        snapWord[w] <= wrData;
    end

    assert_capture_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.capture && !strobes.zero) |=> snapWord[w] == $past(cnt[w*DATA_W +: DATA_W]));

    assert_zero_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
      strobes.zero |=> snapWord[w] == '0);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
      !(strobes.capture || strobes.zero || strobes.wordWr) |=> $stable(snapWord[w]));
  end

  always_comb begin
    rdMux = '0;
    for (int w = 0; w < WORDS; w++)
      if (addr == ADDR_W'(w)) rdMux = snapWord[w];
    if (addr == ADDR_W'(WORDS)) rdMux = ctrlVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      rdValid  <= 1'b0;
      rdWasCmd <= 1'b0;
    end else begin
      rdValid  <= rdEn;
      rdWasCmd <= rdEn && (addr == ADDR_W'(WORDS));
      if (rdEn) rdData <= rdMux;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> cnt == $past(cnt) + 1'b1);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cnt));

  assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  assert_cmd_bits_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdWasCmd) |-> rdData[1:0] == 2'b00);
endmodule

// File: rtl/snapshot_counter.sv
module snapshot_counter
  import snapctr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int WORDS = (CNT_W + DATA_W - 1) / DATA_W;

  strobe_t           strobes;
  logic [DATA_W-1:0] ctrlVal;

  snapctr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strobes(strobes), .ctrlVal(ctrlVal)
  );

  snapctr_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobes(strobes), .wrData(wrData),
    .ctrlVal(ctrlVal), .rdEn(rdEn), .addr(addr), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/test_snapshot_counter.sv
module test_snapshot_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic [3:0]  rdDataS;
  logic        rdValidS;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  snapshot_counter i_snapshot_counter (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid));

  // narrow copy, 8-bit count in two 4-bit words, for wraparound
  snapshot_counter #(.CNT_W(8), .DATA_W(4), .ADDR_W(2)) i_narrow (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData[3:0]), .rdData(rdDataS), .rdValid(rdValidS));

  // reference state
  logic [63:0] mCnt;
  logic [31:0] mSn [2];
  logic [31:0] mCtl;
  logic [3:0]  mSs [2];
  logic [3:0]  mCs;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = '0; mSn[0] = '0; mSn[1] = '0; mCtl = '0;
      mSs[0] = '0; mSs[1] = '0; mCs = '0;
    end else begin
      if (wrEn) begin
        case (addr)
          2'd0: begin mSn[0] = wrData; mSs[0] = wrData[3:0]; end
          2'd1: begin mSn[1] = wrData; mSs[1] = wrData[3:0]; end
          2'd2: begin
            mCtl = {wrData[31:2], 2'b00};
            mCs  = {wrData[3:2], 2'b00};
            if (wrData[1]) begin
              mSn[0] = mCnt[31:0]; mSn[1] = mCnt[63:32];
              mSs[0] = mCnt[3:0];  mSs[1] = mCnt[7:4];
            end
            if (wrData[0]) begin
              mSn[0] = '0; mSn[1] = '0; mSs[0] = '0; mSs[1] = '0;
            end
          end
          default: ;
        endcase
      end
      if (tickEn) mCnt = mCnt + 64'd1;
    end
  end

  typedef struct {
    logic [31:0] e;
    logic [3:0]  es;
    string       tag;
  } item_t;
  item_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, input string tag);
    item_t it;
    @(negedge clk);
    case (a)
      2'd0: begin it.e = mSn[0]; it.es = mSs[0]; end
      2'd1: begin it.e = mSn[1]; it.es = mSs[1]; end
      2'd2: begin it.e = mCtl;   it.es = mCs;    end
      default: begin it.e = '0;  it.es = '0;     end
    endcase
    it.tag = tag;
    sb.push_back(it);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  // monitor: pop one expected item per returned read
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected read", rdData, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rdData == it.e, it.tag, rdData, it.e);
        check(rdValidS && rdDataS == it.es, {it.tag, " narrow"}, {28'd0, rdDataS}, {28'd0, it.es});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(rdValid == 1'b0, "R8 rdValid after reset", {31'd0, rdValid}, 32'd0);
    doRead(2'd0, "R8 low after reset");
    doRead(2'd1, "R8 high after reset");
    doRead(2'd2, "R8 command after reset");
    doRead(2'd3, "R11 unused address read");

    ticks(10);
    doWrite(2'd2, 32'hABCD_0002);
    doRead(2'd0, "R3 capture low");
    doRead(2'd1, "R1 capture high");
    doRead(2'd2, "R4 command bits read zero");

    ticks(5);
    doRead(2'd0, "R3 snapshot stable while counting");
    doWrite(2'd0, 32'h1234_5678);
    doRead(2'd0, "R7 direct low write");
    doRead(2'd1, "R7 high untouched");
    doWrite(2'd1, 32'h9ABC_DEF1);
    doRead(2'd1, "R7 direct high write");
    doRead(2'd0, "R7 low untouched");

    doWrite(2'd2, 32'h0000_0F04);
    doRead(2'd0, "R10 no-command low");
    doRead(2'd1, "R10 no-command high");
    doRead(2'd2, "R4 upper bits stored");

    doWrite(2'd2, 32'h0000_0001);
    doRead(2'd0, "R5 zero low");
    doRead(2'd1, "R5 zero high");

    ticks(300);
    doWrite(2'd2, 32'h0000_0002);
    doRead(2'd0, "R2 wrap low");
    doRead(2'd1, "R2 wrap high");
    doWrite(2'd2, 32'h0000_0002);
    doRead(2'd0, "R2 hold without tick");

    tickEn = 1'b1;
    doWrite(2'd2, 32'h0000_0002);
    doRead(2'd0, "R3 capture during ticking");
    tickEn = 1'b0;

    doWrite(2'd2, 32'h0000_0003);
    doRead(2'd0, "R6 both bits low");
    doRead(2'd1, "R6 both bits high");

    doWrite(2'd0, 32'h0000_00A5);
    doWrite(2'd3, 32'hFFFF_FFFF);
    doRead(2'd0, "R11 write ignored low");
    doRead(2'd1, "R11 write ignored high");
    doRead(2'd2, "R11 write ignored command");
    doRead(2'd3, "R11 unused read after write");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R9 all reads returned", sb.size(), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule